// File: doc/BRIEF.md
# Time-Division Serial Frame Port (GCI / IOM-2 style)

This block terminates a four-wire time-division serial bus of the GCI / IOM-2 kind. The bus carries a clock that runs at twice the bit rate, a frame sync pulse, and one data line in each direction. Inside the block, rising edges of the bus clock are detected with the system clock. The block halves that rate to get bit slots and counts slots from each sync pulse. Each slot takes two bus clock edges. Transmit data is launched on the first edge of a slot, and receive data is sampled on the second.

A frame is either 32 slots (basic rate) or 256 slots (multiplexed, up to eight devices sharing the frame), chosen by a mode input. A per-slot enable mask says which slots the port owns. In owned slots the transmit pin is driven and receive bits are captured. In all other slots the pin is released and the receive bits read as zero. The host side is parallel. One vector holds the next frame's transmit bits, and another holds the last complete frame's receive bits. A one-cycle strobe marks the hand-over. A sync pulse that comes early or late raises a framing-error strobe. A 1x clock output serves attached devices that cannot use the double-rate clock.

Top module: `gci_port`

## Requirements
- R1: While rst_n is low at a clk edge, tx_drive, frame_done, frame_err and every bit of rx_frame are 0 after that edge.
- R2: A bus_sync high at a bus_clk rising edge starts slot 0. Each slot spans two bus_clk rising edges. With mux_mode=0 a frame has 32 slots, and with mux_mode=1 it has 256 slots.
- R3: From the first bus edge of slot s, tx_drive equals slot_en[s]. When it is 1, tx_data carries transmit vector bit index s XOR 7, so each octet is sent most significant bit first.
- R4: rxd is sampled on the second bus edge of slot s. It is stored at rx_frame index s XOR 7 when slot_en[s] is 1. Disabled or unused slots read 0.
- R5: frame_done pulses for exactly one clk cycle after the sample edge of the last slot. rx_frame takes the new frame's value in that same cycle.
- R6: tx_frame is captured into the transmit buffer at frame_done, or at a sync while the port is idle. A change made during a frame only affects the following frame.
- R7: A sync at any edge other than the one right after the last slot of a locked frame pulses frame_err and restarts counting at slot 0.
- R8: If no sync arrives on the edge right after the last slot, frame_err pulses and tx_drive drops to 0. The port then goes idle with no further frame_done until a sync comes.
- R9: With dsc_mode=1, clk_1x is high during the first bus edge interval of each slot and low during the second. With dsc_mode=0, clk_1x follows bus_clk delayed by one clk.
- R10: tx_drive stays 0 while the port is idle (after reset and before the first sync).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk | input | 1 | Double-rate bus clock |
| bus_sync | input | 1 | Frame sync, sampled at bus_clk rising edges |
| rxd | input | 1 | Serial receive data |
| mux_mode | input | 1 | 0: 32-slot frame, 1: 256-slot frame |
| dsc_mode | input | 1 | Selects the divided 1x clock on clk_1x |
| slot_en | input | 256 | Per-slot ownership mask |
| tx_frame | input | 256 | Transmit bits for the next frame |
| rx_frame | output | 256 | Receive bits of the last completed frame |
| frame_done | output | 1 | One-cycle end-of-frame strobe |
| frame_err | output | 1 | One-cycle early/late sync strobe |
| tx_data | output | 1 | Transmit bit value |
| tx_drive | output | 1 | Pad enable; pin released when 0 |
| clk_1x | output | 1 | 1x clock for attached devices |

## Verification
The hardest states to reach are the sync faults. A sync must land in the middle of a locked frame, or must be missing at exactly the edge after the last slot's sample. The directed stimulus drives every bus edge by hand, so the bench can place a sync after ten slots of a locked frame, or withhold it for one edge after a complete frame. The same stimulus then checks that counting restarts cleanly, or that the pin is released and no frame_done follows.

// File: rtl/gci_pkg.sv
// Shared definitions for the time-division serial frame port.
// Assumes slot numbers fit in an int; the bit order inside an octet is MSB first.
package gci_pkg;
    typedef enum logic {
        FRAME_BASIC = 1'b0,
        FRAME_MUX   = 1'b1
    } frame_mode_e;
endpackage

// File: rtl/gci_edge.sv
// Detects rising edges of the double-rate bus clock in the system clock domain
// and selects the 1x clock output. Assumes bus_clk is slower than clk / 2.
module gci_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk,
    input  logic dsc_mode,
    input  logic data_clk,
    output logic tick,
    output logic clk_1x
);
    logic bus_q;

    // Remember the bus clock level of the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_q <= 1'b0;
        else        bus_q <= bus_clk;
    end

    assign tick   = bus_clk & ~bus_q;
    assign clk_1x = dsc_mode ? data_clk : bus_q;

    // R2: two bus edges can never fall in adjacent system cycles
    p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/gci_framer.sv
// Slot and phase counter. Locks on a sync, counts slots of two bus edges each,
// and flags an early or a missing sync. Assumes mux_mode is steady while locked.
module gci_framer #(
    parameter int FRAME_LONG  = 256,
    parameter int FRAME_SHORT = 32,
    localparam int SW = $clog2(FRAME_LONG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          sync,
    input  logic          mux_mode,
    output logic [SW-1:0] slot,
    output logic [SW-1:0] start_slot,
    output logic          locked,
    output logic          bit_start,
    output logic          sample,
    output logic          frame_end,
    output logic          late,
    output logic          restart,
    output logic          frame_err,
    output logic          data_clk
);
    import gci_pkg::*;

    logic          ph;
    logic [SW-1:0] last_idx;
    logic          at_last;
    logic          early;

    // Last slot index for the selected frame length.
    always_comb begin
        if (frame_mode_e'(mux_mode) == FRAME_MUX) last_idx = SW'(FRAME_LONG - 1);
        else                                      last_idx = SW'(FRAME_SHORT - 1);
    end

    assign at_last    = (slot == last_idx);
    assign restart    = tick & sync;
    assign bit_start  = tick & (sync | (locked & ph & ~at_last));
    assign start_slot = sync ? '0 : SW'(slot + 1'b1);
    assign sample     = tick & locked & ~sync & ~ph;
    assign frame_end  = sample & at_last;
    assign late       = tick & locked & ~sync & ph & at_last;
    assign early      = restart & locked & ~(ph & at_last);
    assign data_clk   = ~ph;

    // Advance phase and slot on each bus edge; realign on sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot      <= '0;
            ph        <= 1'b0;
            locked    <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            frame_err <= early | late;
            if (tick) begin
                if (sync) begin
                    slot   <= '0;
                    ph     <= 1'b0;
                    locked <= 1'b1;
                end else if (locked) begin
                    if (!ph) begin
                        ph <= 1'b1;
                    end else if (at_last) begin
                        locked <= 1'b0;
                        ph     <= 1'b0;
                    end else begin
                        slot <= SW'(slot + 1'b1);
                        ph   <= 1'b0;
                    end
                end else begin
                    ph <= ~ph;
                end
            end
        end
    end

    // R2: a locked slot count never passes the last slot of the frame
    p_slot_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> slot <= last_idx);
    // R7: a framing error is only ever raised by a bus edge
    p_err_on_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(tick));
endmodule

// File: rtl/gci_rx.sv
// Receive section: samples rxd in owned slots into a work vector and publishes
// it at frame end. Assumes slot_en is steady across the frame.
module gci_rx #(
    parameter int FRAME_LONG = 256,
    localparam int SW = $clog2(FRAME_LONG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rxd,
    input  logic                  sample,
    input  logic                  frame_end,
    input  logic                  restart,
    input  logic [SW-1:0]         slot,
    input  logic [FRAME_LONG-1:0] slot_en,
    output logic [FRAME_LONG-1:0] rx_frame,
    output logic                  frame_done
);
    logic [FRAME_LONG-1:0] work;
    logic [FRAME_LONG-1:0] work_nxt;

    // Insert the sampled bit at its MSB-first octet position.
    always_comb begin
        work_nxt = work;
        if (sample && slot_en[slot]) work_nxt[slot ^ SW'(7)] = rxd;
    end

    // Collect the frame and hand it over on the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work       <= '0;
            rx_frame   <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_end;
            work       <= restart ? '0 : work_nxt;
            if (frame_end) rx_frame <= work_nxt;
        end
    end

    // R5: the frame strobe lasts one cycle
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

// File: rtl/gci_tx.sv
// Transmit section: buffers the host vector per frame and launches one bit per
// slot, driving the pin only in owned slots. Assumes an external tri-state pad.
module gci_tx #(
    parameter int FRAME_LONG = 256,
    localparam int SW = $clog2(FRAME_LONG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_start,
    input  logic [SW-1:0]         start_slot,
    input  logic                  restart,
    input  logic                  locked,
    input  logic                  frame_end,
    input  logic                  late,
    input  logic [FRAME_LONG-1:0] slot_en,
    input  logic [FRAME_LONG-1:0] tx_frame,
    output logic                  tx_data,
    output logic                  tx_drive
);
    logic [FRAME_LONG-1:0] tx_buf;
    logic [FRAME_LONG-1:0] src;
    logic                  fresh;

    assign fresh = restart & ~locked;
    assign src   = fresh ? tx_frame : tx_buf;

    // Capture the host vector at frame hand-over or at the first sync.
    always_ff @(posedge clk) begin
        if (!rst_n)                  tx_buf <= '0;
        else if (frame_end || fresh) tx_buf <= tx_frame;
    end

    // Launch a bit at each slot start; release the pin on loss of sync.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_data  <= 1'b0;
            tx_drive <= 1'b0;
        end else if (bit_start) begin
            tx_data  <= src[start_slot ^ SW'(7)];
            tx_drive <= slot_en[start_slot];
        end else if (late) begin
            tx_data  <= 1'b0;
            tx_drive <= 1'b0;
        end
    end

    // R8: losing lock always leaves the pin released
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> !tx_drive);
    // R10: the pin is never driven while unlocked
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !locked |-> !tx_drive);
endmodule

// File: rtl/gci_port.sv
// Top of the time-division serial frame port: edge detect, framer, receive and
// transmit sections. Assumes all bus inputs are synchronous or pre-synchronized.
module gci_port #(
    parameter int FRAME_LONG  = 256,
    parameter int FRAME_SHORT = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_clk,
    input  logic                  bus_sync,
    input  logic                  rxd,
    input  logic                  mux_mode,
    input  logic                  dsc_mode,
    input  logic [FRAME_LONG-1:0] slot_en,
    input  logic [FRAME_LONG-1:0] tx_frame,
    output logic [FRAME_LONG-1:0] rx_frame,
    output logic                  frame_done,
    output logic                  frame_err,
    output logic                  tx_data,
    output logic                  tx_drive,
    output logic                  clk_1x
);
    localparam int SW = $clog2(FRAME_LONG);

    logic          tick, data_clk, locked, bit_start, sample;
    logic          frame_end, late, restart;
    logic [SW-1:0] slot, start_slot;

    gci_edge u_edge (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .dsc_mode(dsc_mode),
        .data_clk(data_clk), .tick(tick), .clk_1x(clk_1x)
    );

    gci_framer #(.FRAME_LONG(FRAME_LONG), .FRAME_SHORT(FRAME_SHORT)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sync(bus_sync),
        .mux_mode(mux_mode), .slot(slot), .start_slot(start_slot),
        .locked(locked), .bit_start(bit_start), .sample(sample),
        .frame_end(frame_end), .late(late), .restart(restart),
        .frame_err(frame_err), .data_clk(data_clk)
    );

    gci_rx #(.FRAME_LONG(FRAME_LONG)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .sample(sample),
        .frame_end(frame_end), .restart(restart), .slot(slot),
        .slot_en(slot_en), .rx_frame(rx_frame), .frame_done(frame_done)
    );

    gci_tx #(.FRAME_LONG(FRAME_LONG)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_start(bit_start),
        .start_slot(start_slot), .restart(restart), .locked(locked),
        .frame_end(frame_end), .late(late), .slot_en(slot_en),
        .tx_frame(tx_frame), .tx_data(tx_data), .tx_drive(tx_drive)
    );
endmodule

// File: tb/sim_gci_port.sv
// Directed bench for gci_port: one task per scenario, each checking its own results.
module sim_gci_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_clk = 1'b0, bus_sync = 1'b0, rxd = 1'b0;
    logic         mux_mode = 1'b0, dsc_mode = 1'b0;
    logic [255:0] slot_en = '0, tx_frame = '0;
    logic [255:0] rx_frame;
    logic         frame_done, frame_err, tx_data, tx_drive, clk_1x;

    int n_run = 0, n_fail = 0;
    logic g_done, g_err, g_clk, g_txd, g_drv;
    int   f_dones, f_errs, f_first_err, f_txbad;

    always #2 clk = ~clk;   // 250 MHz

    gci_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_sync(bus_sync),
        .rxd(rxd), .mux_mode(mux_mode), .dsc_mode(dsc_mode),
        .slot_en(slot_en), .tx_frame(tx_frame), .rx_frame(rx_frame),
        .frame_done(frame_done), .frame_err(frame_err), .tx_data(tx_data),
        .tx_drive(tx_drive), .clk_1x(clk_1x)
    );

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_clk = 1'b0; bus_sync = 1'b0; rxd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // One bus clock rising edge; outputs sampled one cycle after the edge.
    task automatic bus_edge(input logic s, input logic r);
        @(negedge clk);
        bus_clk = 1'b1; bus_sync = s; rxd = r;
        @(negedge clk);
        g_done = frame_done; g_err = frame_err; g_clk = clk_1x;
        g_txd = tx_data; g_drv = tx_drive;
        bus_clk = 1'b0; bus_sync = 1'b0;
        @(negedge clk);
    endtask

    // One frame of n slots starting with a sync; tx_exp is the expected transmit
    // vector, tx_next is applied to tx_frame after slot 0.
    task automatic run_frame(input int n, input logic [255:0] tx_exp,
                             input logic [255:0] tx_next, input logic [255:0] rxpat,
                             input logic [255:0] en);
        f_dones = 0; f_errs = 0; f_first_err = 0; f_txbad = 0;
        for (int s = 0; s < n; s++) begin
            bus_edge(s == 0, rxpat[s ^ 7]);
            if (s == 0) begin f_first_err = g_err; tx_frame = tx_next; end
            else if (g_err) f_errs++;
            if (g_done) f_dones++;
            if (g_drv !== en[s]) f_txbad++;
            else if (en[s] && g_txd !== tx_exp[s ^ 7]) f_txbad++;
            bus_edge(1'b0, rxpat[s ^ 7]);
            if (g_err) f_errs++;
            if (g_done) f_dones++;
        end
    endtask

    function automatic logic [255:0] rx_expect(input int n, input logic [255:0] rxpat,
                                               input logic [255:0] en);
        logic [255:0] v = '0;
        for (int s = 0; s < n; s++) if (en[s]) v[s ^ 7] = rxpat[s ^ 7];
        return v;
    endfunction

    task automatic t_reset();
        slot_en = '1; tx_frame = '1;
        do_reset();
        check(tx_drive === 1'b0 && frame_done === 1'b0 && frame_err === 1'b0,
              "R1 reset strobes/drive", {tx_drive, frame_done, frame_err}, 0);
        check(rx_frame === '0, "R1 reset rx_frame", rx_frame, 0);
        bus_edge(1'b0, 1'b1);
        check(g_drv === 1'b0, "R10 idle drive", g_drv, 0);
    endtask

    task automatic t_basic();
        logic [255:0] tx1, rx1, rx2;
        tx1 = {224'h0, 32'hA5C3_0F96}; rx1 = {224'h0, 32'h1234_ABCD};
        rx2 = {224'h0, 32'hFEDC_0123};
        mux_mode = 1'b0; slot_en = {224'h0, 32'hFFFF_FFFF}; tx_frame = tx1;
        do_reset();
        run_frame(32, tx1, tx1, rx1, slot_en);
        check(f_txbad == 0, "R3 tx slots basic", f_txbad, 0);
        check(f_dones == 1 && frame_done === 1'b0, "R5 one done per frame", f_dones, 1);
        check(rx_frame === rx_expect(32, rx1, slot_en), "R4 rx capture basic",
              rx_frame, rx_expect(32, rx1, slot_en));
        check(f_errs == 0 && f_first_err == 0, "R2 32-slot framing no error", f_errs, 0);
        run_frame(32, tx1, tx1, rx2, slot_en);
        check(f_first_err == 0 && f_errs == 0, "R2 back-to-back sync on time",
              f_first_err, 0);
        check(rx_frame === rx_expect(32, rx2, slot_en), "R5 rx updated second frame",
              rx_frame, rx_expect(32, rx2, slot_en));
    endtask

    task automatic t_mask();
        logic [255:0] tx1, rx1;
        tx1 = {224'h0, 32'h5A5A_F00F}; rx1 = {224'h0, 32'hFFFF_FFFF};
        mux_mode = 1'b0; slot_en = {224'h0, 32'hF00F_0FF0}; tx_frame = tx1;
        do_reset();
        run_frame(32, tx1, tx1, rx1, slot_en);
        check(f_txbad == 0, "R3 masked slots release pin", f_txbad, 0);
        check(rx_frame === rx_expect(32, rx1, slot_en), "R4 disabled slots read 0",
              rx_frame, rx_expect(32, rx1, slot_en));
    endtask

    task automatic t_buffer();
        logic [255:0] p1, p2, rx1;
        p1 = {224'h0, 32'hC001_D00D}; p2 = {224'h0, 32'h0BAD_F00D};
        rx1 = {224'h0, 32'h0000_FFFF};
        mux_mode = 1'b0; slot_en = {224'h0, 32'hFFFF_FFFF}; tx_frame = p1;
        do_reset();
        run_frame(32, p1, p2, rx1, slot_en);
        check(f_txbad == 0, "R6 mid-frame change not used", f_txbad, 0);
        run_frame(32, p2, p2, rx1, slot_en);
        check(f_txbad == 0, "R6 change used next frame", f_txbad, 0);
    endtask

    task automatic t_long();
        logic [255:0] tx1, rx1;
        tx1 = {8{32'h9E37_79B9}} ^ {32{8'h3C}}; rx1 = {8{32'h6A09_E667}};
        mux_mode = 1'b1; slot_en = '1; slot_en[200] = 1'b0; tx_frame = tx1;
        do_reset();
        run_frame(256, tx1, tx1, rx1, slot_en);
        check(f_txbad == 0, "R3 tx slots 256", f_txbad, 0);
        check(f_dones == 1 && f_errs == 0, "R2 256-slot frame length", f_dones, 1);
        check(rx_frame === rx_expect(256, rx1, slot_en), "R4 rx capture 256",
              rx_frame, rx_expect(256, rx1, slot_en));
        mux_mode = 1'b0;
    endtask

    task automatic t_early();
        logic [255:0] tx1, rx1;
        tx1 = {224'h0, 32'h8000_0001}; rx1 = {224'h0, 32'hA0A0_5050};
        mux_mode = 1'b0; slot_en = {224'h0, 32'hFFFF_FFFF}; tx_frame = tx1;
        do_reset();
        for (int s = 0; s < 10; s++) begin
            bus_edge(s == 0, 1'b0);
            bus_edge(1'b0, 1'b0);
        end
        run_frame(32, tx1, tx1, rx1, slot_en);
        check(f_first_err == 1, "R7 early sync flagged", f_first_err, 1);
        check(f_txbad == 0 && f_dones == 1, "R7 count restarts at slot 0", f_txbad, 0);
        check(rx_frame === rx_expect(32, rx1, slot_en), "R7 frame after restart",
              rx_frame, rx_expect(32, rx1, slot_en));
    endtask

    task automatic t_late();
        int extra_done, extra_drv;
        mux_mode = 1'b0; slot_en = {224'h0, 32'hFFFF_FFFF}; tx_frame = '1;
        do_reset();
        run_frame(32, '1, '1, '0, slot_en);
        bus_edge(1'b0, 1'b0);
        check(g_err === 1'b1 && g_drv === 1'b0, "R8 missing sync flagged, pin released",
              {g_err, g_drv}, 2'b10);
        extra_done = 0; extra_drv = 0;
        for (int k = 0; k < 70; k++) begin
            bus_edge(1'b0, 1'b1);
            if (g_done) extra_done++;
            if (g_drv) extra_drv++;
        end
        check(extra_done == 0, "R8 no done while idle", extra_done, 0);
        check(extra_drv == 0, "R10 pin stays released while idle", extra_drv, 0);
    endtask

    task automatic t_clk1x();
        logic a, b, c;
        mux_mode = 1'b0; slot_en = '0; dsc_mode = 1'b1;
        do_reset();
        bus_edge(1'b1, 1'b0); a = g_clk;
        bus_edge(1'b0, 1'b0); b = g_clk;
        bus_edge(1'b0, 1'b0); c = g_clk;
        check({a, b, c} === 3'b101, "R9 divided clock phase", {a, b, c}, 3'b101);
        dsc_mode = 1'b0;
        bus_edge(1'b0, 1'b0);
        check(g_clk === 1'b1 && clk_1x === 1'b0, "R9 follows bus clock",
              {g_clk, clk_1x}, 2'b10);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: run did not complete actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_buffer();
        t_long();
        t_early();
        t_late();
        t_clk1x();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule